// File: doc/BRIEF.md
# Security-Banked Exception Status Register

This block is one 32-bit control and state word for the system exception handlers of a processor with two security states. For each fault and system handler it keeps an active flag, and for some of them a pending flag and an enable flag. Most of these flags exist twice, once for the Secure world and once for the Non-secure world. A register access picks its copy from the secure attribute that travels with it. Some flags exist only once. These are either hidden from Non-secure software, shown to it only when a configuration bit hands it ownership of the bus fault, hard fault and NMI, or open to both worlds.

The exception logic next to the block raises and drops flags through set and clear vectors, one vector per copy. All flags are brought out as state vectors, and each flag keeps the bit position it has in the register word. Within one cycle a set input beats a clear input, and a clear input beats a bus write. The read data is combinational.

Top module: `sec_exc_status_reg`

## Requirements
- R1: The register answers only at address `REG_OFFSET` (default 0xD24). A write to any other address changes no flag, and a read from any other address returns zero.
- R2: Twelve flags are banked. Active flags: memory-management fault bit 0, hard fault 2, usage fault 3, supervisor call 7, pended service 10, system tick 11. Pending flags: usage fault 12, memory-management fault 13, supervisor call 15, hard fault 21. Enable flags: memory-management fault 16, usage fault 18. A Secure access reads and writes only the Secure copy, and a Non-secure access reads and writes only the Non-secure copy.
- R3: The secure-fault flags (active 4, enable 19, pending 20) exist once. A Secure access reads and writes them. A Non-secure access reads them as zero and cannot change them.
- R4: The bus-fault flags (active 1, pending 14, enable 17) and the NMI active flag (5) exist once. A Non-secure access sees them only while `ns_owns_faults` is 1. While it is 0, a Non-secure access reads them as zero and cannot change them. A Secure access can always read them.
- R5: A Secure write never changes the Secure hard-fault active flag (bit 2).
- R6: A Non-secure write sets or clears the Non-secure hard-fault pending flag (bit 21).
- R7: The Non-secure hard-fault active flag (bit 2) and the NMI active flag (bit 5) change from a bus write only in one case: a Non-secure write with that bit at 0, while `core_in_secure` is 1 and `ns_owns_faults` is 1. Such a write clears the flag. Writing 1 never sets either flag, and a Secure write does not change NMI active.
- R8: The debug-monitor active flag (bit 8) exists once. Accesses from both worlds can read and write it.
- R9: Bits 6, 9 and 22 to 31 always read as zero. Writing them has no effect.
- R10: Reset clears every flag in both copies and in the single-copy group.
- R11: In the same cycle, a set input beats a clear input on the same flag, and a clear input beats a bus write.
- R12: `st_sec`, `st_nsec` and `st_shared` show the flags at their register bit positions and change on the clock edge that follows the cause. `reg_rdata` follows the current state combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | ADDR_W | Access address |
| reg_wdata | input | DATA_W | Write data |
| reg_we | input | 1 | Write strobe |
| reg_secure | input | 1 | Access is Secure |
| reg_rdata | output | DATA_W | Read data for the current address and attribute |
| core_in_secure | input | 1 | The core is executing in Secure state |
| ns_owns_faults | input | 1 | Hands bus fault, hard fault and NMI to the Non-secure world |
| set_sec | input | DATA_W | Set vector for the Secure copy |
| clr_sec | input | DATA_W | Clear vector for the Secure copy |
| set_nsec | input | DATA_W | Set vector for the Non-secure copy |
| clr_nsec | input | DATA_W | Clear vector for the Non-secure copy |
| set_shared | input | DATA_W | Set vector for the single-copy flags |
| clr_shared | input | DATA_W | Clear vector for the single-copy flags |
| st_sec | output | DATA_W | Secure copy of the banked flags |
| st_nsec | output | DATA_W | Non-secure copy of the banked flags |
| st_shared | output | DATA_W | Single-copy flags |

## Verification
The bench builds the block with its default parameters: a 12-bit address and the register at 0xD24. With these values the bench can also target the neighbouring address 0xD28 and confirm that the register ignores it. It steps through every combination of access world, core state and ownership bit that matters for the alias-clear rule on hard-fault active and NMI active, and it checks that writing ones never sets those two flags. It also drives the set, clear and bus-write paths in the same cycle to confirm the priority order.

// File: rtl/sec_exc_status_reg.sv
module sec_exc_status_reg #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'hD24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_we,
  input  logic              reg_secure,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              core_in_secure,
  input  logic              ns_owns_faults,
  input  logic [DATA_W-1:0] set_sec,
  input  logic [DATA_W-1:0] clr_sec,
  input  logic [DATA_W-1:0] set_nsec,
  input  logic [DATA_W-1:0] clr_nsec,
  input  logic [DATA_W-1:0] set_shared,
  input  logic [DATA_W-1:0] clr_shared,
  output logic [DATA_W-1:0] st_sec,
  output logic [DATA_W-1:0] st_nsec,
  output logic [DATA_W-1:0] st_shared
);
  localparam logic [DATA_W-1:0] HFA_M  = DATA_W'(32'h0000_0004);
  localparam logic [DATA_W-1:0] BANK_M = DATA_W'(32'h0025_BC8D);
  localparam logic [DATA_W-1:0] SECF_M = DATA_W'(32'h0018_0010);
  localparam logic [DATA_W-1:0] BUSF_M = DATA_W'(32'h0002_4002);
  localparam logic [DATA_W-1:0] NMI_M  = DATA_W'(32'h0000_0020);
  localparam logic [DATA_W-1:0] DBG_M  = DATA_W'(32'h0000_0100);
  localparam logic [DATA_W-1:0] SH_M   = SECF_M | BUSF_M | NMI_M | DBG_M;
  localparam logic [DATA_W-1:0] BWR_M  = BANK_M & ~HFA_M;

  logic hit, wr, alias_clr;
  logic [DATA_W-1:0] wm_s, wm_ns, wm_sh, kill_ns, kill_sh;
  logic [DATA_W-1:0] nx_s, nx_ns, nx_sh;

  assign hit       = (reg_addr == REG_OFFSET);
  assign wr        = reg_we && hit;
  assign alias_clr = wr && !reg_secure && core_in_secure && ns_owns_faults;

  assign wm_s    = (wr && reg_secure)  ? BWR_M : '0;
  assign wm_ns   = (wr && !reg_secure) ? BWR_M : '0;
  assign wm_sh   = !wr ? '0 : (DBG_M | (reg_secure ? SECF_M : '0)
                   | ((reg_secure || ns_owns_faults) ? BUSF_M : '0));
  assign kill_ns = (alias_clr && !reg_wdata[2]) ? HFA_M : '0;
  assign kill_sh = (alias_clr && !reg_wdata[5]) ? NMI_M : '0;

  assign nx_s  = ((((st_sec & ~wm_s) | (reg_wdata & wm_s)) & ~clr_sec) | set_sec) & BANK_M;
  assign nx_ns = ((((st_nsec & ~wm_ns & ~kill_ns) | (reg_wdata & wm_ns)) & ~clr_nsec)
                 | set_nsec) & BANK_M;
  assign nx_sh = ((((st_shared & ~wm_sh & ~kill_sh) | (reg_wdata & wm_sh)) & ~clr_shared)
                 | set_shared) & SH_M;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_sec    <= '0;
      st_nsec   <= '0;
      st_shared <= '0;
    end else begin
      st_sec    <= nx_s;
      st_nsec   <= nx_ns;
      st_shared <= nx_sh;
    end
  end

  assign reg_rdata = !hit ? '0 :
                     reg_secure ? (st_sec | st_shared) :
                     (st_nsec | (st_shared & (DBG_M | (ns_owns_faults ? (BUSF_M | NMI_M) : '0))));

  AST_SEC_HFA_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && reg_secure && !set_sec[2] && !clr_sec[2]) |=> $stable(st_sec[2])); // R5
  AST_NS_HFA_NOSET: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_nsec[2]) |=> !$rose(st_nsec[2])); // R7
  AST_NMI_NOSET: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_shared[5]) |=> !$rose(st_shared[5])); // R7
  AST_NS_SECF_WI: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !reg_secure && ((set_shared | clr_shared) & SECF_M) == '0)
    |=> $stable(st_shared & SECF_M)); // R3
  AST_BUSF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !reg_secure && !ns_owns_faults && ((set_shared | clr_shared) & BUSF_M) == '0)
    |=> $stable(st_shared & BUSF_M)); // R4
  AST_NO_CROSS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && reg_secure && (set_nsec | clr_nsec) == '0) |=> $stable(st_nsec)); // R2
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_sec[0] |=> st_sec[0]); // R11
endmodule

// File: tb/sec_exc_status_reg_tb_top.sv
module sec_exc_status_reg_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] reg_addr = 12'hD24;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic reg_we = 1'b0, reg_secure = 1'b0, core_in_secure = 1'b0, ns_owns_faults = 1'b0;
  logic [31:0] set_sec = '0, clr_sec = '0, set_nsec = '0, clr_nsec = '0;
  logic [31:0] set_shared = '0, clr_shared = '0;
  logic [31:0] st_sec, st_nsec, st_shared;

  always #2 clk = ~clk;

  sec_exc_status_reg dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_secure(reg_secure), .reg_rdata(reg_rdata),
    .core_in_secure(core_in_secure), .ns_owns_faults(ns_owns_faults),
    .set_sec(set_sec), .clr_sec(clr_sec), .set_nsec(set_nsec), .clr_nsec(clr_nsec),
    .set_shared(set_shared), .clr_shared(clr_shared),
    .st_sec(st_sec), .st_nsec(st_nsec), .st_shared(st_shared));

  typedef struct { int sel; logic [31:0] exp; string tag; } item_t;
  item_t sb[$];
  event sample_ev;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  initial begin
    forever begin
      @(sample_ev);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        case (it.sel)
          0: act = reg_rdata;
          1: act = st_sec;
          2: act = st_nsec;
          default: act = st_shared;
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(int sel, logic [31:0] exp, string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    ->sample_ev;
    #2;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, logic sec,
                    logic [31:0] ss = '0, logic [31:0] cs = '0);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_secure = sec; reg_we = 1'b1;
    set_sec = ss; clr_sec = cs;
    @(negedge clk);
    reg_we = 1'b0; set_sec = '0; clr_sec = '0; reg_addr = 12'hD24;
  endtask

  task automatic pulse(int which, logic [31:0] v);
    @(negedge clk);
    if (which == 0) set_sec = v; else if (which == 1) set_nsec = v; else set_shared = v;
    @(negedge clk);
    set_sec = '0; set_nsec = '0; set_shared = '0;
  endtask

  task automatic rd(logic [11:0] a, logic sec, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_addr = a; reg_secure = sec; reg_we = 1'b0;
    expect_val(0, exp, tag);
  endtask

  initial begin
    #80000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_val(1, 32'h0, "R10 sec bank after reset");
    expect_val(2, 32'h0, "R10 nsec bank after reset");
    expect_val(3, 32'h0, "R10 shared after reset");
    rd(12'hD24, 1'b1, 32'h0, "R10 secure read after reset");

    core_in_secure = 1'b1; ns_owns_faults = 1'b0;
    wr(12'hD24, 32'hFFFF_FFFF, 1'b1);
    expect_val(1, 32'h0025_BC89, "R2 R5 secure write all ones");
    expect_val(2, 32'h0, "R2 nsec copy untouched");
    expect_val(3, 32'h001A_4112, "R3 R4 R8 shared after secure write");
    rd(12'hD24, 1'b1, 32'h003F_FD9B, "R9 R12 secure view, reserved zero");
    rd(12'hD24, 1'b0, 32'h0000_0100, "R3 R4 NS view hides secfault and busfault");
    ns_owns_faults = 1'b1;
    rd(12'hD24, 1'b0, 32'h0002_4102, "R4 NS view with ownership");

    ns_owns_faults = 1'b0; core_in_secure = 1'b0;
    wr(12'hD24, 32'hFFFF_FFFF, 1'b0);
    expect_val(2, 32'h0025_BC89, "R2 R6 NS write all ones");
    expect_val(1, 32'h0025_BC89, "R2 sec copy untouched by NS");
    expect_val(3, 32'h001A_4112, "R3 R4 shared after NS write");
    wr(12'hD24, 32'h0, 1'b0);
    expect_val(2, 32'h0, "R6 NS clears own copy incl bit 21");
    expect_val(3, 32'h001A_4012, "R8 R3 R4 NS clears debug only");
    ns_owns_faults = 1'b1;
    wr(12'hD24, 32'h0, 1'b0);
    expect_val(3, 32'h0018_0010, "R4 NS owner clears busfault");

    pulse(1, 32'h4);
    pulse(2, 32'h20);
    expect_val(2, 32'h4, "R12 set nsec hard active");
    expect_val(3, 32'h0018_0030, "R12 set NMI active");
    wr(12'hD24, 32'hFFFF_FFFF, 1'b0);
    expect_val(2, 32'h0025_BC8D, "R7 ones keep NS hard active");
    expect_val(3, 32'h001A_4132, "R7 ones keep NMI");
    core_in_secure = 1'b1;
    wr(12'hD24, 32'hFFFF_FFFF, 1'b0);
    expect_val(2, 32'h0025_BC8D, "R7 ones never clear");
    ns_owns_faults = 1'b0;
    wr(12'hD24, 32'h0, 1'b0);
    expect_val(2, 32'h4, "R7 no clear without ownership");
    expect_val(3, 32'h001A_4032, "R7 NMI kept without ownership");
    ns_owns_faults = 1'b1;
    wr(12'hD24, 32'h0, 1'b0);
    expect_val(2, 32'h0, "R7 alias clear of NS hard active");
    expect_val(3, 32'h0018_0010, "R7 alias clear of NMI");

    pulse(2, 32'h20);
    wr(12'hD24, 32'h0, 1'b1);
    expect_val(3, 32'h20, "R7 R3 secure write keeps NMI, clears secfault");
    expect_val(1, 32'h0, "R2 secure zero write");
    pulse(0, 32'h4);
    wr(12'hD24, 32'h0, 1'b1);
    expect_val(1, 32'h4, "R5 secure hard active read-only");
    wr(12'hD24, 32'hFFFF_FFFF, 1'b1);
    expect_val(1, 32'h0025_BC8D, "R5 secure write keeps hard active");

    wr(12'hD24, 32'h0, 1'b1, 32'h1, 32'h0);
    expect_val(1, 32'h5, "R11 set beats bus write");
    wr(12'hD24, 32'hFFFF_FFFF, 1'b1, 32'h80, 32'h88);
    expect_val(1, 32'h0025_BC85, "R11 clear beats write, set beats clear");

    wr(12'hD28, 32'h0, 1'b1);
    expect_val(1, 32'h0025_BC85, "R1 other address write ignored");
    rd(12'hD28, 1'b1, 32'h0, "R1 other address reads zero");
    rd(12'hD24, 1'b1, 32'h003F_FDB7, "R12 secure read follows state");
    rd(12'hD24, 1'b0, 32'h0002_4122, "R4 R12 NS owner view");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule